// File: doc/BRIEF.md
# Asymmetric Saturating Confidence Table

This block holds one small saturating confidence counter per table slot and tells a load value predictor whether its guess for a given load is trustworthy enough to use. The slot is chosen from the load's program counter. A lookup port returns the current counter value and a single high-confidence flag. When that flag is low, the surrounding pipeline makes no prediction for the load.

An update port reports how an earlier prediction turned out. A correct outcome moves the counter up by one step, clipped at its maximum. A wrong outcome moves it down by a larger step, clipped at zero. Confidence therefore builds slowly and collapses quickly. The counter width, both step sizes, the threshold, the table depth, the program-counter bits that are skipped and the index-forming variant are all parameters. Elaboration-time checks reject settings that do not fit together.

Top module: `conf_gate_table`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every counter to 0, so every lookup reads level 0 with the confidence flag low until updates arrive.
- R2: An update with upd_en=1 and upd_ok=1 raises the addressed 3-bit counter by 1, visible at lookup one clock edge later.
- R3: A correct-outcome update to a counter already at 7 leaves it at 7.
- R4: An update with upd_en=1 and upd_ok=0 lowers the addressed counter by 3 when it holds 3 or more.
- R5: A wrong-outcome update to a counter holding 0, 1 or 2 sets it to 0.
- R6: lkp_conf is 1 exactly when lkp_level is 5 or greater. lkp_level is the counter at the looked-up slot.
- R7: In the default direct variant, the slot is pc bits [7:2] (64 slots, 2 skipped low bits). Two PCs with equal bits [7:2] share a counter. PCs with different bits [7:2] never affect each other.
- R8: A lookup to the slot being updated in the same cycle returns the value before the update. The new value appears after the clock edge.
- R9: With upd_en=0, the counters do not change, whatever upd_pc and upd_ok hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_pc | input | PC_W | Program counter of the load being looked up |
| upd_en | input | 1 | Apply an outcome this cycle |
| upd_pc | input | PC_W | Program counter of the load whose outcome is reported |
| upd_ok | input | 1 | 1 = prediction was correct, 0 = it missed |
| lkp_conf | output | 1 | High-confidence flag for lkp_pc |
| lkp_level | output | CTR_W | Counter value for lkp_pc |

## Verification
A corrupted counter shows at lkp_level as soon as its slot is looked up. It also shows at lkp_conf whenever the wrong value falls on the other side of the threshold. A wrong step or a clipping fault appears one clock after the update that caused it. An index fault appears as two PCs that should be independent moving together, or two aliasing PCs disagreeing. A long run of correct outcomes followed by misses walks one slot through every level and both clipping limits, so any arithmetic slip shifts the rest of that trajectory.

// File: rtl/conf_pkg.sv
package conf_pkg;

   // Variants for turning a program counter into a table slot number.
   localparam int IDX_DIRECT = 0;
   localparam int IDX_FOLD   = 1;

   // Slot-number width for a table of n entries (never below one bit).
   function automatic int slot_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // One saturating step of a confidence counter.
   function automatic int sat_step(input int cur, input logic ok,
                                   input int up, input int down, input int top);
      if (ok) begin
         return (cur + up > top) ? top : cur + up;
      end
      return (cur < down) ? 0 : cur - down;
   endfunction

endpackage

// File: rtl/conf_index.sv
module conf_index
   import conf_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int PC_LSB = 2,
   parameter int IDX_W  = 6,
   parameter int MODE   = IDX_DIRECT
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);

   localparam int LOW_END = PC_LSB + IDX_W;

   if (LOW_END > PC_W) begin : g_bad_span
      $error("conf_index: skipped bits plus slot bits exceed PC width");
   end

   if (MODE == IDX_FOLD) begin : g_fold
      localparam int HIGH_END = LOW_END + IDX_W;
      if (HIGH_END > PC_W) begin : g_bad_fold
         $error("conf_index: fold variant needs two slot-wide fields in the PC");
      end
      assign idx = pc[PC_LSB +: IDX_W] ^ pc[LOW_END +: IDX_W];
   end else begin : g_direct
      assign idx = pc[PC_LSB +: IDX_W];
   end

endmodule

// File: rtl/conf_step.sv
module conf_step
   import conf_pkg::*;
#(
   parameter int CTR_W = 3,
   parameter int UP    = 1,
   parameter int DOWN  = 3
) (
   input  logic [CTR_W-1:0] cur,
   input  logic             ok,
   output logic [CTR_W-1:0] nxt
);

   localparam int TOP = (1 << CTR_W) - 1;

   always_comb begin
      nxt = CTR_W'(sat_step(int'(cur), ok, UP, DOWN, TOP));
   end

endmodule

// File: rtl/conf_store.sv
module conf_store #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6,
   parameter int CTR_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CTR_W-1:0] wr_val,
   input  logic [IDX_W-1:0] rd_a_idx,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic [CTR_W-1:0] rd_a_val,
   output logic [CTR_W-1:0] rd_b_val
);

   logic [CTR_W-1:0] ctr [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            ctr[e] <= '0;
         end
      end else if (wr_en) begin
         ctr[wr_idx] <= wr_val;
      end
   end

   // Reads see the stored state, so a same-cycle write is not yet visible.
   assign rd_a_val = ctr[rd_a_idx];
   assign rd_b_val = ctr[rd_b_idx];

endmodule

// File: rtl/conf_gate_table.sv
module conf_gate_table
   import conf_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int PC_LSB    = 2,
   parameter int ENTRIES   = 64,
   parameter int IDX_MODE  = IDX_DIRECT,
   parameter int CTR_W     = 3,
   parameter int INC_STEP  = 1,
   parameter int DEC_STEP  = 3,
   parameter int THRESH    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  lkp_pc,
   input  logic             upd_en,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic             upd_ok,
   output logic             lkp_conf,
   output logic [CTR_W-1:0] lkp_level
);

   localparam int IDX_W   = slot_bits(ENTRIES);
   localparam int CTR_MAX = (1 << CTR_W) - 1;

   if ((ENTRIES & (ENTRIES - 1)) != 0 || ENTRIES < 2) begin : g_bad_depth
      $error("conf_gate_table: ENTRIES must be a power of two, at least 2");
   end
   if (CTR_W < 1 || CTR_W > 8) begin : g_bad_width
      $error("conf_gate_table: CTR_W out of range");
   end
   if (INC_STEP < 1 || INC_STEP > CTR_MAX || DEC_STEP < 1 || DEC_STEP > CTR_MAX) begin : g_bad_step
      $error("conf_gate_table: steps must lie between 1 and the counter maximum");
   end
   if (THRESH < 1 || THRESH > CTR_MAX) begin : g_bad_thresh
      $error("conf_gate_table: threshold must be reachable and nonzero");
   end
   if (IDX_MODE != IDX_DIRECT && IDX_MODE != IDX_FOLD) begin : g_bad_mode
      $error("conf_gate_table: unknown index variant");
   end

   logic [IDX_W-1:0] lkp_idx;
   logic [IDX_W-1:0] upd_idx;
   logic [CTR_W-1:0] upd_level;
   logic [CTR_W-1:0] upd_next;

   conf_index #(
      .PC_W  (PC_W),
      .PC_LSB(PC_LSB),
      .IDX_W (IDX_W),
      .MODE  (IDX_MODE)
   ) u_lkp_index (
      .pc (lkp_pc),
      .idx(lkp_idx)
   );

   conf_index #(
      .PC_W  (PC_W),
      .PC_LSB(PC_LSB),
      .IDX_W (IDX_W),
      .MODE  (IDX_MODE)
   ) u_upd_index (
      .pc (upd_pc),
      .idx(upd_idx)
   );

   conf_store #(
      .ENTRIES(ENTRIES),
      .IDX_W  (IDX_W),
      .CTR_W  (CTR_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (upd_en),
      .wr_idx  (upd_idx),
      .wr_val  (upd_next),
      .rd_a_idx(lkp_idx),
      .rd_b_idx(upd_idx),
      .rd_a_val(lkp_level),
      .rd_b_val(upd_level)
   );

   conf_step #(
      .CTR_W(CTR_W),
      .UP   (INC_STEP),
      .DOWN (DEC_STEP)
   ) u_step (
      .cur(upd_level),
      .ok (upd_ok),
      .nxt(upd_next)
   );

   assign lkp_conf = (lkp_level >= CTR_W'(THRESH));

endmodule

// File: rtl/conf_gate_table_chk.sv
module conf_gate_table_chk #(
   parameter int PC_W   = 32,
   parameter int CTR_W  = 3,
   parameter int THRESH = 5,
   parameter int INC    = 1,
   parameter int DEC    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PC_W-1:0]  upd_pc,
   input logic             upd_en,
   input logic             upd_ok,
   input logic             lkp_conf,
   input logic [CTR_W-1:0] lkp_level,
   input logic [CTR_W-1:0] upd_cur
);

   localparam int TOP = (1 << CTR_W) - 1;

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lkp_level == '0 && !lkp_conf));

   // R6
   threshold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_conf == (int'(lkp_level) >= THRESH));

   // R2
   raise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_ok && int'(upd_cur) + INC <= TOP)
      |=> (upd_pc != $past(upd_pc)) || (int'(upd_cur) == int'($past(upd_cur)) + INC));

   // R3
   top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_ok && int'(upd_cur) == TOP)
      |=> (upd_pc != $past(upd_pc)) || (int'(upd_cur) == TOP));

   // R4
   drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_ok && int'(upd_cur) >= DEC)
      |=> (upd_pc != $past(upd_pc)) || (int'(upd_cur) == int'($past(upd_cur)) - DEC));

   // R5
   floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_ok && int'(upd_cur) < DEC)
      |=> (upd_pc != $past(upd_pc)) || (upd_cur == '0));

   // R9
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> (upd_pc != $past(upd_pc)) || $stable(upd_cur));

endmodule

bind conf_gate_table conf_gate_table_chk #(
   .PC_W  (PC_W),
   .CTR_W (CTR_W),
   .THRESH(THRESH),
   .INC   (INC_STEP),
   .DEC   (DEC_STEP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .upd_pc   (upd_pc),
   .upd_en   (upd_en),
   .upd_ok   (upd_ok),
   .lkp_conf (lkp_conf),
   .lkp_level(lkp_level),
   .upd_cur  (upd_level)
);

// File: tb/conf_gate_table_test.sv
module conf_gate_table_test;

   localparam int CLK_P = 10;
   localparam logic [31:0] PC_A     = 32'h0000_1000;  // slot 0
   localparam logic [31:0] PC_A_ALS = 32'h0000_1101;  // bits [7:2] = 0 too
   localparam logic [31:0] PC_B     = 32'h0000_1004;  // slot 1
   localparam logic [31:0] PC_C     = 32'h0000_10FC;  // slot 63

   // Vector: {outcome_ok, expected level[2:0], expected flag}
   localparam int NVEC = 16;
   localparam logic [4:0] VEC [NVEC] = '{
      5'b1_001_0, 5'b1_010_0, 5'b1_011_0, 5'b1_100_0,
      5'b1_101_1, 5'b1_110_1, 5'b1_111_1, 5'b1_111_1,
      5'b0_100_0, 5'b1_101_1, 5'b0_010_0, 5'b0_000_0,
      5'b0_000_0, 5'b1_001_0, 5'b0_000_0, 5'b1_001_0
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lkp_pc = '0;
   logic        upd_en = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_ok = 1'b0;
   logic        lkp_conf;
   logic [2:0]  lkp_level;

   int checks = 0;
   int errors = 0;

   always #(CLK_P / 2) clk = ~clk;

   conf_gate_table uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .lkp_pc   (lkp_pc),
      .upd_en   (upd_en),
      .upd_pc   (upd_pc),
      .upd_ok   (upd_ok),
      .lkp_conf (lkp_conf),
      .lkp_level(lkp_level)
   );

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic peek(input logic [31:0] pc, input int lvl, input int flag, input string tag);
      lkp_pc = pc;
      #1;
      check({tag, " level"}, int'(lkp_level), lvl);
      check({tag, " flag"}, int'(lkp_conf), flag);
   endtask

   // Apply one update across a rising edge; returns at the following negedge.
   task automatic apply(input logic en, input logic [31:0] pc, input logic ok);
      upd_en = en;
      upd_pc = pc;
      upd_ok = ok;
      @(posedge clk);
      @(negedge clk);
      upd_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at several slots
      peek(PC_A, 0, 0, "R1 reset A");
      peek(PC_C, 0, 0, "R1 reset C");
      rst_n = 1'b1;
      @(negedge clk);
      peek(PC_B, 0, 0, "R1 after release B");

      // Table walk on slot 0: R2 R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         apply(1'b1, PC_A, VEC[i][4]);
         peek(PC_A, int'(VEC[i][3:1]), int'(VEC[i][0]),
              $sformatf("R2/R3/R4/R5/R6 vector %0d", i));
      end

      // R7: other slots untouched, aliasing PC shares slot 0 (level 1)
      peek(PC_B, 0, 0, "R7 neighbour slot");
      peek(PC_C, 0, 0, "R7 far slot");
      peek(PC_A_ALS, 1, 0, "R7 alias read");
      apply(1'b1, PC_A_ALS, 1'b1);
      peek(PC_A, 2, 0, "R7 alias write");
      apply(1'b1, PC_B, 1'b1);
      peek(PC_A, 2, 0, "R7 isolation A");
      peek(PC_B, 1, 0, "R7 isolation B");

      // R9: disabled update leaves counters alone
      apply(1'b0, PC_A, 1'b1);
      peek(PC_A, 2, 0, "R9 disabled ok");
      apply(1'b0, PC_A, 1'b0);
      peek(PC_A, 2, 0, "R9 disabled miss");

      // R8: same-cycle lookup sees pre-update value
      lkp_pc = PC_A;
      upd_en = 1'b1;
      upd_pc = PC_A;
      upd_ok = 1'b1;
      #1;
      check("R8 pre-update level", int'(lkp_level), 2);
      @(posedge clk);
      #1;
      check("R8 post-update level", int'(lkp_level), 3);
      @(negedge clk);
      upd_en = 1'b0;

      // R6 boundary: 4 -> flag low, 5 -> flag high
      apply(1'b1, PC_A, 1'b1);
      peek(PC_A, 4, 0, "R6 level four");
      apply(1'b1, PC_A, 1'b1);
      peek(PC_A, 5, 1, "R6 level five");

      // R1: mid-run reset clears everything
      rst_n = 1'b0;
      #1;
      peek(PC_A, 0, 0, "R1 mid-run A");
      peek(PC_B, 0, 0, "R1 mid-run B");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      apply(1'b1, PC_A, 1'b0);
      peek(PC_A, 0, 0, "R5 miss from zero after reset");

      finish_run();
   end

endmodule